// File: doc/BRIEF.md
# Graphics Command Packet Framer

This block sits between a stream of 32-bit graphics command words and the units that execute them. Each word arrives under a valid/ready handshake. The top byte of the first word of every command selects how many words belong to it. The block gathers those words and then hands the finished packet on, one word per cycle, with a start flag on the first beat and an end flag on the last. The output side has no back-pressure.

Some opcodes are not forwarded as packets:
- **Line-strip opcodes** have no fixed length. They are streamed through as each word arrives, and the packet ends at the first word that matches a terminator pattern.
- **Image-transfer opcodes** consume three words and produce a single start pulse for a separate transfer unit. The pulse carries the position word, the size word and a read/write flag.
- **Settings opcodes** are one-word commands. They overwrite one of eight latched settings registers. Two of those registers feed the low bits of a status word, and any register can be read back combinationally through a select input.

A fixed-length command whose words have not all arrived is held. Nothing is emitted for it until the last word is accepted, however long the gap between words.

Top module: `cmd_framer`

## Requirements
- R1: After reset, `statusWord` is 0x14802000, settings register i reads (0xE0+i)<<24, `outValid` and `xferStart` are low and `inReady` is high.
- R2: The opcode is bits 31:24 of a command's first word. A fixed command is 1 + N words long, where N depends on the opcode:
  - N = 2 for 0x02, 0x40-0x47 and 0x60-0x63
  - N = 3 for 0x20-0x23, 0x50-0x57, 0x64-0x67 and 0x80
  - N = 4 for 0x28-0x2B
  - N = 5 for 0x30-0x33
  - N = 6 for 0x24-0x27
  - N = 7 for 0x38-0x3B
  - N = 8 for 0x2C-0x2F and 0x34-0x37
  - N = 11 for 0x3C-0x3F
  - N = 1 for 0x68-0x6B, 0x70-0x73 and 0x78-0x7B
  - N = 2 for 0x74-0x77 and 0x7C-0x7F

  The packet is emitted unchanged and in order. `outFirst` is set on its first beat and `outLast` on its final beat.
- R3: A fixed command is emitted only after all its words have been accepted. No output beat appears while it is incomplete, even across idle cycles.
- R4: Every other opcode that is not a settings, transfer or line-strip opcode is emitted as a one-word packet with `outFirst` and `outLast` both set. This includes 0x00, 0x6C-0x6F, 0x81-0x9F and 0xE8-0xFF.
- R5: For opcodes 0x48-0x4F, words are emitted as accepted. The packet ends at the first word at index 3 or later (opcode word = index 0) for which (word & 0xF000F000) == 0x50005000. Matches at index 1 or 2 are ordinary data.
- R6: For opcodes 0x58-0x5F, the terminator is recognised only at even indices of 4 or more. Matches at odd indices or below index 4 are ordinary data.
- R7: Opcodes 0xA0-0xDF take three words and are not emitted. One cycle after the third word is accepted, `xferStart` pulses for one cycle with `xferPos` = word 1 and `xferSize` = word 2. `xferRead` is 1 exactly when opcode bits 7:5 are 110.
- R8: An opcode with bits 7:3 = 11100 is not emitted. It replaces settings register (opcode & 7) with the whole word, which `cfgData` shows when `cfgSel` selects that register.
- R9: After each settings write, `statusWord[10:0]` equals settings register 1 bits 10:0 and `statusWord[12:11]` equals settings register 6 bits 1:0. `statusWord[31:13]` never changes.
- R10: While a buffered packet is being emitted, `inReady` is low; it is low in the cycle right after a fixed command's last word is accepted. During a line strip `inReady` stays high until the terminator is accepted.
- R11: `outFirst` and `outLast` occur only with `outValid`, and packets never interleave: each beat after an end beat starts a new packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Command word offered |
| inReady | output | 1 | Block can accept a word this cycle |
| inWord | input | 32 | Command word |
| outValid | output | 1 | Packet beat valid |
| outWord | output | 32 | Packet beat data |
| outFirst | output | 1 | First beat of a packet |
| outLast | output | 1 | Final beat of a packet |
| xferStart | output | 1 | One-cycle image-transfer start pulse |
| xferRead | output | 1 | Transfer direction, 1 = read |
| xferPos | output | 32 | Transfer position word |
| xferSize | output | 32 | Transfer size word |
| statusWord | output | 32 | Status word with settings-derived low bits |
| cfgSel | input | 3 | Settings register select |
| cfgData | output | 32 | Selected settings register |

## Verification
The assertions watch, on every cycle, the beat framing: flags only with valid, no start inside an open packet, a start after every end. They also check that transfer pulses last one cycle and never coincide with a packet beat, and that the upper status bits never move.

The length table, the terminator rules for both strip kinds, the holding of partial commands, the settings bank contents and the transfer fields all depend on which words were sent. Only the bench's scenarios show these, by comparing every emitted beat and every transfer pulse against a reference built from the requirements.

// File: rtl/cmd_framer_pkg.sv
package cmd_framer_pkg;

  localparam int WORD_W      = 32;
  localparam int OP_W        = 8;
  localparam int MAX_PKT     = 12;
  localparam int IDX_W       = $clog2(MAX_PKT);
  localparam int SET_NUM     = 8;
  localparam int SET_IDX_W   = $clog2(SET_NUM);
  localparam int POLY_IDX_W  = 3;

  localparam logic [WORD_W-1:0] TERM_MASK   = 32'hF000_F000;
  localparam logic [WORD_W-1:0] TERM_MATCH  = 32'h5000_5000;
  localparam logic [WORD_W-1:0] STATUS_INIT = 32'h1480_2000;
  localparam int STAT_LO_W = 11;
  localparam int STAT_HI_W = 2;
  localparam int STAT_KEEP = WORD_W - STAT_LO_W - STAT_HI_W;

  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_DRAIN   = 2'd1,
    ST_POLY    = 2'd2
  } frmState_t;

  typedef struct packed {
    logic             bufWe;
    logic [IDX_W-1:0] bufIdx;
    logic             drainEn;
    logic [IDX_W-1:0] drainIdx;
    logic             polyEmit;
    logic             markFirst;
    logic             markLast;
    logic             setWe;
    logic             xferFire;
    logic             xferRead;
  } ctrlStrb_t;

  function automatic logic [IDX_W-1:0] extraWords(input logic [OP_W-1:0] op);
    logic [IDX_W-1:0] n;
    case (op) inside
      8'h02:           n = IDX_W'(2);
      [8'h20:8'h23]:   n = IDX_W'(3);
      [8'h24:8'h27]:   n = IDX_W'(6);
      [8'h28:8'h2B]:   n = IDX_W'(4);
      [8'h2C:8'h2F]:   n = IDX_W'(8);
      [8'h30:8'h33]:   n = IDX_W'(5);
      [8'h34:8'h37]:   n = IDX_W'(8);
      [8'h38:8'h3B]:   n = IDX_W'(7);
      [8'h3C:8'h3F]:   n = IDX_W'(11);
      [8'h40:8'h47]:   n = IDX_W'(2);
      [8'h50:8'h57]:   n = IDX_W'(3);
      [8'h60:8'h63]:   n = IDX_W'(2);
      [8'h64:8'h67]:   n = IDX_W'(3);
      [8'h68:8'h6B]:   n = IDX_W'(1);
      [8'h70:8'h73]:   n = IDX_W'(1);
      [8'h74:8'h77]:   n = IDX_W'(2);
      [8'h78:8'h7B]:   n = IDX_W'(1);
      [8'h7C:8'h7F]:   n = IDX_W'(2);
      8'h80:           n = IDX_W'(3);
      default:         n = '0;
    endcase
    return n;
  endfunction

  function automatic logic isSetting(input logic [OP_W-1:0] op);
    return op[7:3] == 5'b11100;
  endfunction

  function automatic logic isXfer(input logic [OP_W-1:0] op);
    return (op >= 8'hA0) && (op <= 8'hDF);
  endfunction

  function automatic logic isPolyMono(input logic [OP_W-1:0] op);
    return op[7:3] == 5'b01001;
  endfunction

  function automatic logic isPolyShaded(input logic [OP_W-1:0] op);
    return op[7:3] == 5'b01011;
  endfunction

endpackage

// File: rtl/cmd_framer_ctrl.sv
module cmd_framer_ctrl
  import cmd_framer_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  input  logic [OP_W-1:0] opcode,
  input  logic            termHit,
  output logic            inReady,
  output ctrlStrb_t       strb
);

  frmState_t             state, stateN;
  logic [IDX_W-1:0]      cnt, cntN;
  logic [IDX_W-1:0]      pktLen, pktLenN;
  logic [IDX_W-1:0]      drainIdx, drainIdxN;
  logic                  xferMode, xferModeN;
  logic                  xferDir, xferDirN;
  logic [POLY_IDX_W-1:0] polyIdx, polyIdxN;
  logic                  polyOdd, polyOddN;
  logic                  polyShaded, polyShadedN;
  logic                  accept;
  logic                  termNow;

  localparam logic [IDX_W-1:0] XFER_LAST_IDX = IDX_W'(2);
  localparam logic [POLY_IDX_W-1:0] POLY_SAT = '1;

  assign inReady = (state != ST_DRAIN);
  assign accept  = inValid && inReady;

  always_comb begin
    strb        = '0;
    stateN      = state;
    cntN        = cnt;
    pktLenN     = pktLen;
    drainIdxN   = drainIdx;
    xferModeN   = xferMode;
    xferDirN    = xferDir;
    polyIdxN    = polyIdx;
    polyOddN    = polyOdd;
    polyShadedN = polyShaded;
    termNow     = 1'b0;

    case (state)
      ST_COLLECT: begin
        if (accept) begin
          if (cnt == '0) begin
            if (isSetting(opcode)) begin
              strb.setWe = 1'b1;
            end else if (isXfer(opcode)) begin
              strb.bufWe  = 1'b1;
              strb.bufIdx = '0;
              cntN        = IDX_W'(1);
              xferModeN   = 1'b1;
              xferDirN    = (opcode[7:5] == 3'b110);
            end else if (isPolyMono(opcode) || isPolyShaded(opcode)) begin
              strb.polyEmit  = 1'b1;
              strb.markFirst = 1'b1;
              stateN         = ST_POLY;
              polyIdxN       = POLY_IDX_W'(1);
              polyOddN       = 1'b1;
              polyShadedN    = isPolyShaded(opcode);
            end else begin
              strb.bufWe  = 1'b1;
              strb.bufIdx = '0;
              xferModeN   = 1'b0;
              pktLenN     = extraWords(opcode) + IDX_W'(1);
              if (extraWords(opcode) == '0) begin
                stateN    = ST_DRAIN;
                drainIdxN = '0;
              end else begin
                cntN = IDX_W'(1);
              end
            end
          end else begin
            strb.bufWe  = 1'b1;
            strb.bufIdx = cnt;
            if (xferMode) begin
              if (cnt == XFER_LAST_IDX) begin
                strb.xferFire = 1'b1;
                strb.xferRead = xferDir;
                cntN          = '0;
              end else begin
                cntN = cnt + IDX_W'(1);
              end
            end else if (cnt == pktLen - IDX_W'(1)) begin
              stateN    = ST_DRAIN;
              drainIdxN = '0;
              cntN      = '0;
            end else begin
              cntN = cnt + IDX_W'(1);
            end
          end
        end
      end

      ST_DRAIN: begin
        strb.drainEn   = 1'b1;
        strb.drainIdx  = drainIdx;
        strb.markFirst = (drainIdx == '0);
        strb.markLast  = (drainIdx == pktLen - IDX_W'(1));
        if (drainIdx == pktLen - IDX_W'(1)) begin
          stateN = ST_COLLECT;
        end else begin
          drainIdxN = drainIdx + IDX_W'(1);
        end
      end

      ST_POLY: begin
        if (accept) begin
          if (polyShaded) begin
            termNow = termHit && (polyIdx >= POLY_IDX_W'(4)) && !polyOdd;
          end else begin
            termNow = termHit && (polyIdx >= POLY_IDX_W'(3));
          end
          strb.polyEmit = 1'b1;
          strb.markLast = termNow;
          if (termNow) begin
            stateN = ST_COLLECT;
          end
          if (polyIdx != POLY_SAT) begin
            polyIdxN = polyIdx + POLY_IDX_W'(1);
          end
          polyOddN = !polyOdd;
        end
      end

      default: stateN = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_COLLECT;
      cnt        <= '0;
      pktLen     <= IDX_W'(1);
      drainIdx   <= '0;
      xferMode   <= 1'b0;
      xferDir    <= 1'b0;
      polyIdx    <= '0;
      polyOdd    <= 1'b0;
      polyShaded <= 1'b0;
    end else begin
      state      <= stateN;
      cnt        <= cntN;
      pktLen     <= pktLenN;
      drainIdx   <= drainIdxN;
      xferMode   <= xferModeN;
      xferDir    <= xferDirN;
      polyIdx    <= polyIdxN;
      polyOdd    <= polyOddN;
      polyShaded <= polyShadedN;
    end
  end

endmodule

// File: rtl/cmd_framer_dpath.sv
module cmd_framer_dpath
  import cmd_framer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [WORD_W-1:0]    inWord,
  input  ctrlStrb_t            strb,
  input  logic [SET_IDX_W-1:0] cfgSel,
  output logic                 termHit,
  output logic                 outValid,
  output logic [WORD_W-1:0]    outWord,
  output logic                 outFirst,
  output logic                 outLast,
  output logic                 xferStart,
  output logic                 xferRead,
  output logic [WORD_W-1:0]    xferPos,
  output logic [WORD_W-1:0]    xferSize,
  output logic [WORD_W-1:0]    statusWord,
  output logic [WORD_W-1:0]    cfgData
);

  localparam int STAT_LO_SRC = 1;
  localparam int STAT_HI_SRC = 6;

  logic [WORD_W-1:0]    pktBuf  [MAX_PKT];
  logic [WORD_W-1:0]    setBank [SET_NUM];
  logic [SET_IDX_W-1:0] setSel;
  logic [WORD_W-1:0]    loSrcNext, hiSrcNext;

  assign termHit = ((inWord & TERM_MASK) == TERM_MATCH);
  assign setSel  = inWord[WORD_W-OP_W +: SET_IDX_W];
  assign cfgData = setBank[cfgSel];

  always_ff @(posedge clk) begin
    if (strb.bufWe) begin
      pktBuf[strb.bufIdx] <= inWord;
    end
  end

  for (genvar g = 0; g < SET_NUM; g++) begin : gSetReg
    always_ff @(posedge clk) begin
      if (rst) begin
        setBank[g] <= {OP_W'(8'hE0 + g), {(WORD_W-OP_W){1'b0}}};
      end else if (strb.setWe && (setSel == SET_IDX_W'(g))) begin
        setBank[g] <= inWord;
      end
    end
  end

  assign loSrcNext = (setSel == SET_IDX_W'(STAT_LO_SRC)) ? inWord : setBank[STAT_LO_SRC];
  assign hiSrcNext = (setSel == SET_IDX_W'(STAT_HI_SRC)) ? inWord : setBank[STAT_HI_SRC];

  always_ff @(posedge clk) begin
    if (rst) begin
      statusWord <= STATUS_INIT;
    end else if (strb.setWe) begin
      statusWord <= {statusWord[WORD_W-1 -: STAT_KEEP],
                     hiSrcNext[STAT_HI_W-1:0],
                     loSrcNext[STAT_LO_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outWord  <= '0;
      outFirst <= 1'b0;
      outLast  <= 1'b0;
    end else begin
      outValid <= strb.drainEn || strb.polyEmit;
      outWord  <= strb.drainEn ? pktBuf[strb.drainIdx] : inWord;
      outFirst <= strb.markFirst;
      outLast  <= strb.markLast;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xferStart <= 1'b0;
      xferRead  <= 1'b0;
      xferPos   <= '0;
      xferSize  <= '0;
    end else begin
      xferStart <= strb.xferFire;
      if (strb.xferFire) begin
        xferRead <= strb.xferRead;
        xferPos  <= pktBuf[1];
        xferSize <= inWord;
      end
    end
  end

endmodule

// File: rtl/cmd_framer.sv
module cmd_framer
  import cmd_framer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  output logic                 inReady,
  input  logic [WORD_W-1:0]    inWord,
  output logic                 outValid,
  output logic [WORD_W-1:0]    outWord,
  output logic                 outFirst,
  output logic                 outLast,
  output logic                 xferStart,
  output logic                 xferRead,
  output logic [WORD_W-1:0]    xferPos,
  output logic [WORD_W-1:0]    xferSize,
  output logic [WORD_W-1:0]    statusWord,
  input  logic [SET_IDX_W-1:0] cfgSel,
  output logic [WORD_W-1:0]    cfgData
);

  ctrlStrb_t strb;
  logic      termHit;

  cmd_framer_ctrl uCtrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .opcode  (inWord[WORD_W-1 -: OP_W]),
    .termHit (termHit),
    .inReady (inReady),
    .strb    (strb)
  );

  cmd_framer_dpath uDpath (
    .clk        (clk),
    .rst        (rst),
    .inWord     (inWord),
    .strb       (strb),
    .cfgSel     (cfgSel),
    .termHit    (termHit),
    .outValid   (outValid),
    .outWord    (outWord),
    .outFirst   (outFirst),
    .outLast    (outLast),
    .xferStart  (xferStart),
    .xferRead   (xferRead),
    .xferPos    (xferPos),
    .xferSize   (xferSize),
    .statusWord (statusWord),
    .cfgData    (cfgData)
  );

endmodule

// File: rtl/cmd_framer_checker.sv
module cmd_framer_checker (
  input logic        clk,
  input logic        rst,
  input logic        outValid,
  input logic        outFirst,
  input logic        outLast,
  input logic        xferStart,
  input logic [31:0] statusWord
);

  logic inPkt;

  always_ff @(posedge clk) begin
    if (rst) begin
      inPkt <= 1'b0;
    end else if (outValid) begin
      inPkt <= !outLast;
    end
  end

  a_r11_flags_need_valid: assert property (@(posedge clk) disable iff (rst)
    (outFirst || outLast) |-> outValid);

  a_r11_no_restart_inside: assert property (@(posedge clk) disable iff (rst)
    (outValid && inPkt) |-> !outFirst);

  a_r11_start_after_end: assert property (@(posedge clk) disable iff (rst)
    (outValid && !inPkt) |-> outFirst);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    xferStart |=> !xferStart);

  a_r7_no_beat_with_xfer: assert property (@(posedge clk) disable iff (rst)
    xferStart |-> !outValid);

  a_r9_upper_status_fixed: assert property (@(posedge clk) disable iff (rst)
    $stable(statusWord[31:13]));

endmodule

bind cmd_framer cmd_framer_checker uChk (
  .clk        (clk),
  .rst        (rst),
  .outValid   (outValid),
  .outFirst   (outFirst),
  .outLast    (outLast),
  .xferStart  (xferStart),
  .statusWord (statusWord)
);

// File: tb/tb_cmd_framer.sv
module tb_cmd_framer;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic        inReady;
  logic [31:0] inWord;
  logic        outValid;
  logic [31:0] outWord;
  logic        outFirst;
  logic        outLast;
  logic        xferStart;
  logic        xferRead;
  logic [31:0] xferPos;
  logic [31:0] xferSize;
  logic [31:0] statusWord;
  logic [2:0]  cfgSel;
  logic [31:0] cfgData;

  always #5 clk = ~clk;

  cmd_framer dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inWord(inWord),
    .outValid(outValid), .outWord(outWord), .outFirst(outFirst), .outLast(outLast),
    .xferStart(xferStart), .xferRead(xferRead), .xferPos(xferPos), .xferSize(xferSize),
    .statusWord(statusWord), .cfgSel(cfgSel), .cfgData(cfgData)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [33:0] beatQ[$];
  string       beatTag[$];
  logic [64:0] xferQ[$];
  logic [31:0] mSet[8];

  function automatic logic [31:0] mStatus();
    return {19'h0A401, mSet[6][1:0], mSet[1][10:0]};
  endfunction

  function automatic int refExtra(input logic [7:0] op);
    if (op == 8'h02) return 2;
    if (op >= 8'h20 && op <= 8'h3F) begin
      case (op[4:2])
        3'd0: return 3;  3'd1: return 6;  3'd2: return 4;  3'd3: return 8;
        3'd4: return 5;  3'd5: return 8;  3'd6: return 7;  default: return 11;
      endcase
    end
    if (op >= 8'h40 && op <= 8'h47) return 2;
    if (op >= 8'h50 && op <= 8'h57) return 3;
    if (op >= 8'h60 && op <= 8'h7F) begin
      case (op[4:2])
        3'd0: return 2;  3'd1: return 3;  3'd2: return 1;  3'd3: return 0;
        3'd4: return 1;  3'd5: return 2;  3'd6: return 1;  default: return 2;
      endcase
    end
    if (op == 8'h80) return 3;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (outValid) begin
        if (beatQ.size() == 0) begin
          chk(1'b0, "R3 unexpected beat", {30'd0, outFirst, outLast, outWord}, 64'd0);
        end else begin
          logic [33:0] e;
          string t;
          e = beatQ.pop_front();
          t = beatTag.pop_front();
          chk({outFirst, outLast, outWord} == e, t, {30'd0, outFirst, outLast, outWord}, {30'd0, e});
        end
      end
      if (xferStart) begin
        if (xferQ.size() == 0) begin
          chk(1'b0, "R7 unexpected transfer", {32'd0, xferPos}, 64'd0);
        end else begin
          logic [64:0] x;
          x = xferQ.pop_front();
          chk(xferRead == x[64], "R7 read flag", {63'd0, xferRead}, {63'd0, x[64]});
          chk(xferPos == x[63:32], "R7 position", {32'd0, xferPos}, {32'd0, x[63:32]});
          chk(xferSize == x[31:0], "R7 size", {32'd0, xferSize}, {32'd0, x[31:0]});
        end
      end
      chk(statusWord == mStatus(), "R9 status", {32'd0, statusWord}, {32'd0, mStatus()});
    end
  end

  task automatic send(input logic [31:0] w);
    bit r;
    @(negedge clk);
    inWord  = w;
    inValid = 1'b1;
    forever begin
      r = inReady;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
    #1 inValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] bodyWord(input logic [7:0] op, input int i);
    return 32'h0300_0100 + {op, 8'h00, 8'(i), 8'(i * 3)};
  endfunction

  task automatic fixedPkt(input logic [7:0] op, input string tag, input bit checkStall);
    int n;
    logic [31:0] w;
    n = refExtra(op) + 1;
    for (int i = 0; i < n; i++) begin
      w = (i == 0) ? {op, 24'h00C0DE} : bodyWord(op, i);
      beatQ.push_back({i == 0, i == n - 1, w});
      beatTag.push_back(tag);
    end
    for (int i = 0; i < n; i++) begin
      w = (i == 0) ? {op, 24'h00C0DE} : bodyWord(op, i);
      send(w);
    end
    if (checkStall) begin
      @(negedge clk);
      chk(inReady == 1'b0, "R10 ready low while emitting", {63'd0, inReady}, 64'd0);
    end
  endtask

  task automatic polyPkt(input logic [7:0] op, input int termAt, input int decoyA, input int decoyB, input string tag);
    logic [31:0] ws[$];
    bit shaded;
    int endAt;
    shaded = (op[4] == 1'b1);
    for (int i = 0; i <= termAt; i++) begin
      if (i == 0) ws.push_back({op, 24'h00AB12});
      else if (i == termAt) ws.push_back(32'h5ABC_5DEF);
      else if (i == decoyA || i == decoyB) ws.push_back(32'h5000_5000 | 32'(i));
      else ws.push_back(32'h1000_2000 + 32'(i));
    end
    endAt = -1;
    for (int i = 1; i < ws.size() && endAt < 0; i++) begin
      if ((ws[i] & 32'hF000F000) == 32'h50005000) begin
        if (!shaded && i >= 3) endAt = i;
        if (shaded && i >= 4 && (i % 2 == 0)) endAt = i;
      end
    end
    for (int i = 0; i <= endAt; i++) begin
      beatQ.push_back({i == 0, i == endAt, ws[i]});
      beatTag.push_back(tag);
    end
    for (int i = 0; i <= endAt; i++) begin
      send(ws[i]);
      if (i > 0 && i < endAt) begin
        chk(inReady == 1'b1, "R10 ready held in strip", {63'd0, inReady}, 64'd1);
      end
    end
  endtask

  task automatic xfer(input logic [7:0] op, input logic [31:0] pos, input logic [31:0] sz);
    xferQ.push_back({op[7:5] == 3'b110, pos, sz});
    send({op, 24'h000000});
    send(pos);
    send(sz);
  endtask

  task automatic setting(input logic [31:0] w);
    send(w);
    mSet[w[26:24]] = w;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rst     = 1'b1;
    inValid = 1'b0;
    inWord  = '0;
    cfgSel  = '0;
    for (int i = 0; i < 8; i++) mSet[i] = {8'(8'hE0 + i), 24'h0};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(statusWord == 32'h1480_2000, "R1 status reset", {32'd0, statusWord}, 64'h1480_2000);
    chk(outValid == 1'b0, "R1 no beat in reset", {63'd0, outValid}, 64'd0);
    chk(xferStart == 1'b0, "R1 no transfer in reset", {63'd0, xferStart}, 64'd0);
    chk(inReady == 1'b1, "R1 ready in reset", {63'd0, inReady}, 64'd1);
    for (int i = 0; i < 8; i++) begin
      cfgSel = 3'(i);
      #1;
      chk(cfgData == mSet[i], "R1 settings reset", {32'd0, cfgData}, {32'd0, mSet[i]});
    end
    rst = 1'b0;

    fixedPkt(8'h20, "R2 opcode 0x20", 1'b1);
    fixedPkt(8'h3C, "R2 opcode 0x3C", 1'b1);
    fixedPkt(8'h02, "R2 fill", 1'b0);
    fixedPkt(8'h2D, "R2 opcode 0x2D", 1'b0);
    fixedPkt(8'h36, "R2 opcode 0x36", 1'b0);
    fixedPkt(8'h39, "R2 opcode 0x39", 1'b0);
    fixedPkt(8'h31, "R2 opcode 0x31", 1'b0);
    fixedPkt(8'h45, "R2 opcode 0x45", 1'b0);
    fixedPkt(8'h52, "R2 opcode 0x52", 1'b0);
    fixedPkt(8'h66, "R2 opcode 0x66", 1'b0);
    fixedPkt(8'h68, "R2 opcode 0x68", 1'b0);
    fixedPkt(8'h7D, "R2 opcode 0x7D", 1'b0);
    fixedPkt(8'h80, "R2 opcode 0x80", 1'b0);

    fixedPkt(8'h00, "R4 opcode 0x00", 1'b1);
    fixedPkt(8'h6C, "R4 opcode 0x6C", 1'b0);
    fixedPkt(8'h9F, "R4 opcode 0x9F", 1'b0);
    fixedPkt(8'hE8, "R4 opcode 0xE8", 1'b0);
    fixedPkt(8'hFF, "R4 opcode 0xFF", 1'b0);

    idle(20);
    begin
      logic [31:0] w;
      for (int i = 0; i < 5; i++) begin
        w = (i == 0) ? 32'h2800_0000 : bodyWord(8'h28, i);
        beatQ.push_back({i == 0, i == 4, w});
        beatTag.push_back("R3 held packet");
      end
      send(32'h2800_0000);
      send(bodyWord(8'h28, 1));
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        chk(outValid == 1'b0, "R3 nothing while partial", {63'd0, outValid}, 64'd0);
      end
      for (int i = 2; i < 5; i++) send(bodyWord(8'h28, i));
    end

    polyPkt(8'h48, 5, 2, 1, "R5 strip with early decoys");
    polyPkt(8'h4F, 3, -1, -1, "R5 shortest strip");
    polyPkt(8'h58, 6, 3, 5, "R6 shaded odd decoys");
    polyPkt(8'h5E, 4, 2, -1, "R6 shaded low decoy");

    xfer(8'hA0, 32'h0012_0034, 32'h0008_0010);
    xfer(8'hC0, 32'h0100_0200, 32'h0002_0004);
    xfer(8'hDF, 32'h0001_0001, 32'h0003_0005);
    xfer(8'hBF, 32'h0077_0066, 32'h0001_0001);

    setting(32'hE100_0ABC);
    setting(32'hE600_0003);
    setting(32'hE3AB_CDEF);
    setting(32'hE600_0001);
    setting(32'hE100_07FF);
    idle(2);
    for (int i = 0; i < 8; i++) begin
      cfgSel = 3'(i);
      #1;
      chk(cfgData == mSet[i], "R8 settings bank", {32'd0, cfgData}, {32'd0, mSet[i]});
    end
    chk(statusWord[12:0] == {2'b01, 11'h7FF}, "R9 status low bits", {51'd0, statusWord[12:0]}, 64'h0FFF);

    fixedPkt(8'h24, "R2 after settings", 1'b1);
    idle(30);
    chk(beatQ.size() == 0, "R2 all beats seen", 64'(beatQ.size()), 64'd0);
    chk(xferQ.size() == 0, "R7 all transfers seen", 64'(xferQ.size()), 64'd0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule